// File: doc/BRIEF.md
# Double-Error-Correcting Protected FIFO

This block is a storage queue that keeps every 16-bit word under a code able to repair any two bit flips. On the write side an encoder appends 10 check bits to each word, and the resulting 26-bit codeword goes into a 64-entry synchronous FIFO. On the read side a combinational decoder repairs the registered FIFO output before it reaches the data port. The code is a binary BCH code of length 31 with minimum distance 5, shortened to 26 bits by holding its five top data positions at zero. The decoder forms two syndromes over GF(2^5) and solves the error-locator polynomial. It searches only the 26 positions that exist.

A 26-bit XOR mask sits between the encoder and the FIFO. It flips chosen codeword bits on their way into storage so that the repair path can be exercised. In normal use the mask is held at zero. The encoder and decoder are separate modules and also work wired directly to each other.

Top module: `ecc_store_path`

## Requirements
- R1: While reset is active (sampled at a rising edge) and on the first cycle after it, `empty` is 1, `full` is 0 and `dout_vld` is 0.
- R2: Words are delivered in the order they were accepted. No word is lost or repeated.
- R3: A read is accepted when `rd_en` is 1 and `empty` is 0 at a rising edge. `dout_vld` is 1 in the following cycle, with the word on `dout`. In any other cycle `dout_vld` is 0.
- R4: `full` is 1 after 64 accepted writes with no reads. A write while `full` is 1 is dropped and leaves the stored contents and the flags unchanged. `full` and `empty` are never both 1.
- R5: A read while `empty` is 1 is ignored. It produces no `dout_vld` and leaves the queue state unchanged.
- R6: Bit k of `inj_mask` flips codeword bit k as the word is written. Bits 9..0 are check bits and bit k for k >= 10 is data bit k-10. Any single flipped bit is corrected, so `dout` equals the written `din`.
- R7: Any two distinct flipped bits, in data or check positions, are corrected on the FIFO path.
- R8: The encoder feeding the decoder directly, with no FIFO between them, returns the original data for every pattern of zero, one or two flipped codeword bits.
- R9: `uncorr` is 1 only in a cycle where `dout_vld` is 1. It stays 0 for every word stored with at most two flipped bits.
- R10: A write and a read in the same cycle with the queue neither empty nor full are both performed. Occupancy stays the same. A write in a cycle with `empty` at 1 always clears `empty`, even if `rd_en` is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| din | input | 16 | Write data |
| inj_mask | input | 26 | XOR mask applied to the codeword before storage; zero in normal use |
| rd_en | input | 1 | Read request |
| dout | output | 16 | Corrected read data |
| dout_vld | output | 1 | Read data valid, one cycle after an accepted read |
| full | output | 1 | Queue holds 64 entries |
| empty | output | 1 | Queue holds no entries |
| uncorr | output | 1 | Current read word could not be corrected and is passed through |

## Verification
The properties assume that `inj_mask` carries at most two set bits on any accepted write. Under that assumption `uncorr` must never rise. The flow-control properties make no assumption about `rd_en` and `wr_en` against the flags, because the block itself must ignore reads while empty and writes while full. The stimulus only ever builds masks of zero, one or two distinct bits. It also issues requests against both flags on purpose, so that the dropped cases are actually exercised.

// File: rtl/ecc_pkg.sv
// Shared constants and GF(2^5) arithmetic for the double-error-correcting path.
// Assumes the field is built on x^5 + x^2 + 1 and the code is a length-31
// BCH code shortened to CW_W bits.
package ecc_pkg;
    localparam int DATA_W = 16;
    localparam int CHK_W  = 10;
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int GF_M   = 5;
    localparam int GF_N   = (1 << GF_M) - 1;
    // Generator x^10+x^9+x^8+x^6+x^5+x^3+1, leading term implied
    localparam logic [CHK_W-1:0] GEN_LOW = 10'b1101101001;
    localparam logic [GF_M-1:0]  FIELD_LOW = 5'b00101;

    // Multiply one field element by alpha
    function automatic logic [GF_M-1:0] gf_times_alpha(input logic [GF_M-1:0] a);
        return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? FIELD_LOW : '0);
    endfunction

    // General field product by shift-and-add
    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                               input logic [GF_M-1:0] b);
        logic [GF_M-1:0] acc;
        logic [GF_M-1:0] sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_times_alpha(sh);
        end
        return acc;
    endfunction

    // alpha raised to a non-negative power
    function automatic logic [GF_M-1:0] gf_alpha(input int n);
        logic [GF_M-1:0] v;
        int e;
        e = n % GF_N;
        v = 5'd1;
        for (int k = 0; k < GF_N; k++) begin
            if (k < e) v = gf_times_alpha(v);
        end
        return v;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
// Systematic encoder: places the data word in the upper codeword bits and the
// remainder of data(x)*x^CHK_W modulo the generator in the lower bits.
// Purely combinational; assumes the package generator polynomial.
module ecc_encoder
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CW_W-1:0]   cw_out
);
    logic [CHK_W-1:0] rem;

    // Long division of the shifted data polynomial, most significant bit first
    always_comb begin
        logic fb;
        rem = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = data_in[i] ^ rem[CHK_W-1];
            rem = {rem[CHK_W-2:0], 1'b0};
            if (fb) rem = rem ^ GEN_LOW;
        end
    end

    assign cw_out = {data_in, rem};
endmodule

// File: rtl/ecc_decoder.sv
// Combinational double-error corrector. Computes S1 and S3 over GF(2^5),
// handles the zero, single and double cases and searches the CW_W valid
// positions for locator roots. When the roots do not land on the expected
// number of valid positions the data is passed through and uncorr is raised.
module ecc_decoder
    import ecc_pkg::*;
(
    input  logic [CW_W-1:0]   cw_in,
    output logic [DATA_W-1:0] data_out,
    output logic              uncorr
);
    logic [GF_M-1:0]   s1, s3, s1_cubed, s1_inv, sigma2;
    logic              no_err, one_err;
    logic [DATA_W-1:0] flip;
    int                root_cnt;

    // Syndrome accumulation over the received positions
    always_comb begin
        s1 = '0;
        s3 = '0;
        for (int i = 0; i < CW_W; i++) begin
            if (cw_in[i]) begin
                s1 = s1 ^ gf_alpha(i);
                s3 = s3 ^ gf_alpha(3 * i);
            end
        end
    end

    // Locator coefficients and case selection
    always_comb begin
        s1_cubed = gf_mul(gf_mul(s1, s1), s1);
        s1_inv   = '0;
        for (int b = 1; b <= GF_N; b++) begin
            if (gf_mul(s1, GF_M'(b)) == 5'd1) s1_inv = GF_M'(b);
        end
        sigma2  = gf_mul(s3 ^ s1_cubed, s1_inv);
        no_err  = (s1 == '0) && (s3 == '0);
        one_err = (s1 != '0) && (s3 == s1_cubed);
    end

    // Root search across the valid positions, flips recorded for data bits
    always_comb begin
        logic hit;
        flip     = '0;
        root_cnt = 0;
        for (int j = 0; j < CW_W; j++) begin
            if (one_err)
                hit = (gf_alpha(j) == s1);
            else
                hit = (s1 != '0) &&
                      ((gf_alpha(2 * j) ^ gf_mul(s1, gf_alpha(j)) ^ sigma2) == '0);
            if (hit) begin
                root_cnt = root_cnt + 1;
                if (j >= CHK_W) flip[j-CHK_W] = 1'b1;
            end
        end
    end

    // Apply the correction only when the root count matches the case
    always_comb begin
        if (no_err) begin
            uncorr   = 1'b0;
            data_out = cw_in[CW_W-1:CHK_W];
        end else if ((one_err && root_cnt == 1) || (!one_err && root_cnt == 2)) begin
            uncorr   = 1'b0;
            data_out = cw_in[CW_W-1:CHK_W] ^ flip;
        end else begin
            uncorr   = 1'b1;
            data_out = cw_in[CW_W-1:CHK_W];
        end
    end
endmodule

// File: rtl/ecc_fifo.sv
// Single-clock FIFO with a registered read port. Writes while full and reads
// while empty are ignored. Read data and its valid bit appear one cycle after
// an accepted read. Synchronous active-low reset clears pointers and count.
module ecc_fifo #(
    parameter int WIDTH = 26,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             pop_vld,
    output logic             is_full,
    output logic             is_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_wr, do_rd;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign do_wr    = push && !is_full;
    assign do_rd    = pop && !is_empty;

    // Storage array write
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_data <= '0;
            pop_vld  <= 1'b0;
        end else begin
            pop_vld <= do_rd;
            if (do_rd) pop_data <= mem[rptr];
        end
    end
endmodule

// File: rtl/ecc_store_path.sv
// Protected storage path: encoder, error-injection XOR, FIFO and decoder.
// Assumes inj_mask is zero in normal use; the decoder repairs up to two
// flipped codeword bits per entry.
module ecc_store_path
    import ecc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    input  logic [CW_W-1:0]   inj_mask,
    input  logic              rd_en,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              full,
    output logic              empty,
    output logic              uncorr
);
    logic [CW_W-1:0] enc_cw, wr_cw, rd_cw;
    logic            dec_uncorr;

    ecc_encoder u_enc (
        .data_in (din),
        .cw_out  (enc_cw)
    );

    assign wr_cw = enc_cw ^ inj_mask;

    ecc_fifo #(.WIDTH(CW_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_cw),
        .pop       (rd_en),
        .pop_data  (rd_cw),
        .pop_vld   (dout_vld),
        .is_full   (full),
        .is_empty  (empty)
    );

    ecc_decoder u_dec (
        .cw_in    (rd_cw),
        .data_out (dout),
        .uncorr   (dec_uncorr)
    );

    assign uncorr = dout_vld && dec_uncorr;
endmodule

// File: rtl/ecc_store_path_chk.sv
// Port-level properties of the protected storage path, bound to the top.
module ecc_store_path_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic dout_vld,
    input logic full,
    input logic empty,
    input logic uncorr
);
    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty) |=> dout_vld);

    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !empty) |=> !dout_vld);

    // R4
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> full);

    // R10
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> !empty);

    // R9
    uncorr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr |-> dout_vld);
endmodule

bind ecc_store_path ecc_store_path_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .dout_vld (dout_vld),
    .full     (full),
    .empty    (empty),
    .uncorr   (uncorr)
);

// File: tb/ecc_store_path_tb.sv
module ecc_store_path_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] din = '0;
    logic [25:0] inj_mask = '0;
    logic        rd_en = 1'b0;
    logic [15:0] dout;
    logic        dout_vld, full, empty, uncorr;

    int checks = 0;
    int errors = 0;
    int pops = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    logic [15:0] bb_din = '0;
    logic [25:0] bb_mask = '0;
    logic [25:0] bb_cw;
    logic [15:0] bb_dout;
    logic        bb_unc;

    always #5 clk = ~clk;

    ecc_store_path u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .inj_mask(inj_mask),
        .rd_en(rd_en), .dout(dout), .dout_vld(dout_vld), .full(full),
        .empty(empty), .uncorr(uncorr)
    );

    ecc_encoder u_bb_enc (.data_in(bb_din), .cw_out(bb_cw));
    ecc_decoder u_bb_dec (.cw_in(bb_cw ^ bb_mask), .data_out(bb_dout), .uncorr(bb_unc));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FIFO_CHECK FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [15:0] pat(input int k);
        return 16'hACE1 ^ 16'(k * 16'h3B1D) ^ 16'(k << 9);
    endfunction

    // Driver: one cycle of stimulus; records expected words for accepted writes
    task automatic cyc(input bit wr, input logic [15:0] d, input logic [25:0] m,
                       input bit rd);
        @(negedge clk);
        wr_en = wr; din = d; inj_mask = m; rd_en = rd;
        if (wr && !full) exp_q.push_back(d);
    endtask

    task automatic idle();
        cyc(1'b0, '0, '0, 1'b0);
    endtask

    // Monitor: compare each delivered word against the scoreboard
    always @(negedge clk) begin
        if (rst_n && dout_vld) begin
            pops++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 valid without pending word", 32'(dout), 32'hx);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(dout == e, "R2/R6/R7 read data", 32'(dout), 32'(e));
                check(uncorr == 1'b0, "R9 uncorr on correctable word", 32'(uncorr), 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(empty == 1'b1 && full == 1'b0 && dout_vld == 1'b0, "R1 during reset",
              32'({empty, full, dout_vld}), 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(empty == 1'b1 && full == 1'b0 && dout_vld == 1'b0, "R1 after reset",
              32'({empty, full, dout_vld}), 32'b100);

        // R2 ordering, clean words
        for (int k = 0; k < 5; k++) cyc(1'b1, pat(k), '0, 1'b0);
        // R3 latency: read issued here, valid seen at the next negedge
        cyc(1'b0, '0, '0, 1'b1);
        @(negedge clk);
        rd_en = 1'b0;
        check(dout_vld == 1'b1, "R3 valid one cycle after read", 32'(dout_vld), 1);
        @(negedge clk);
        check(dout_vld == 1'b0, "R3 no valid without read", 32'(dout_vld), 0);
        for (int k = 0; k < 4; k++) cyc(1'b0, '0, '0, 1'b1);
        idle();
        idle();
        check(empty == 1'b1 && pops == 5, "R2 all words delivered once",
              32'(pops), 5);

        // R5 read while empty
        base = pops;
        cyc(1'b0, '0, '0, 1'b1);
        idle();
        check(dout_vld == 1'b0 && empty == 1'b1, "R5 read on empty ignored",
              32'({dout_vld, empty}), 32'b01);
        idle();

        // R6 fill to the top with single flips, R4 full and dropped write
        for (int k = 0; k < 64; k++) cyc(1'b1, pat(100 + k), 26'(1) << (k % 26), 1'b0);
        idle();
        check(full == 1'b1 && empty == 1'b0, "R4 full after 64 writes",
              32'({full, empty}), 32'b10);
        cyc(1'b1, 16'hDEAD, '0, 1'b0);
        idle();
        check(full == 1'b1, "R4 full after dropped write", 32'(full), 1);
        base = pops;
        for (int k = 0; k < 64; k++) cyc(1'b0, '0, '0, 1'b1);
        idle();
        idle();
        check(empty == 1'b1 && pops - base == 64, "R4 exactly 64 entries stored",
              32'(pops - base), 64);
        check(exp_q.size() == 0, "R4 dropped write not delivered", 32'(exp_q.size()), 0);

        // R10 write and read together on an empty queue: only the write lands
        cyc(1'b1, pat(500), '0, 1'b1);
        idle();
        check(empty == 1'b0, "R10 write on empty with read", 32'(empty), 0);

        // R7 double flips, streaming with simultaneous write and read
        for (int i = 0; i < 26; i++) begin
            int j;
            j = (i * 7 + 3) % 26;
            if (j == i) j = (i + 1) % 26;
            cyc(1'b1, pat(600 + i), (26'(1) << i) | (26'(1) << j), 1'b1);
        end
        cyc(1'b0, '0, '0, 1'b1);
        idle();
        check(empty == 1'b1, "R10 occupancy held by paired traffic", 32'(empty), 1);
        idle();
        check(exp_q.size() == 0, "R7 all double-error words delivered",
              32'(exp_q.size()), 0);

        // R8 encoder and decoder back to back, every zero/one/two flip pattern
        for (int t = 0; t < 3; t++) begin
            bb_din = pat(900 + t);
            for (int i = -1; i < 26; i++) begin
                for (int j = i; j < 26; j++) begin
                    bb_mask = '0;
                    if (i >= 0) bb_mask[i] = 1'b1;
                    if (j >= 0) bb_mask[j] = 1'b1;
                    #1;
                    check(bb_dout == bb_din && bb_unc == 1'b0, "R8 back-to-back",
                          32'({bb_unc, bb_dout}), 32'(bb_din));
                end
            end
        end

        finish_run();
    end
endmodule